// File: doc/BRIEF.md
# Calendar Clock Register Core

This block holds the time of day and the calendar in a small byte-wide register file reached through a plain synchronous bus: an address, write data, a write enable and a registered read port. Ten bytes carry seconds, minutes and hours, an alarm byte beside each of those three, the weekday, the day of the month, the month and a two-digit year. Two control bytes and two status bytes follow them.

A once-per-second `tick` starts an update. The block raises an in-progress flag for a fixed window of clock cycles and then advances the whole count in one cycle, carrying from seconds up through the year. The same counters run in packed BCD or in plain binary, and the hour byte runs in 24-hour or 12-hour form, chosen by control bits. A freeze bit lets software load a consistent time without updates landing in between. One cycle after each completed update the block pulses `upd_done` for the interrupt logic next to it.

Top module: `cal_clock_core`

## Requirements
- R1: The address map is 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 flags, 13 status; reads of other addresses return 0. After reset the weekday, day and month read 1, every other time and alarm byte reads 0, control A reads 0x26 and control B reads 0x02. Read data appears on `rdata` one clock after the address.
- R2: Each update adds one second; seconds wrap from 59 to 0 and then carry into minutes, which wrap from 59 to 0 and carry into the hour.
- R3: With control B bit 1 at 1 the hour counts 0 to 23, and its wrap from 23 to 0 carries into the day.
- R4: With control B bit 1 at 0 the hour byte holds 1 to 12 in bits 6:0 and a PM flag in bit 7; 11 goes to 12 with the PM flag inverted, 12 goes to 1 with the flag kept, and only the step from 11 PM to 12 AM carries into the day.
- R5: Control B bit 2 at 0 makes every counter packed BCD (0x59 is fifty-nine); at 1 every counter is plain binary.
- R6: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 28 in month 2 (day 29 when the year is a multiple of 4) and after day 31 otherwise; the month wraps from 12 to 1 and carries into the year, which wraps from 99 to 0.
- R7: The weekday counts 1 to 7 and advances on every day carry, wrapping from 7 to 1.
- R8: While control B bit 7 is 1 no update changes the time bytes and no `upd_done` pulse appears; writing that bit to 1 while an update window is open cancels that update.
- R9: Control A bit 7 reads 1 for the UIP_LEAD cycles from the clock edge that accepts a tick until the edge that applies the update, and 0 otherwise; writes to it are ignored.
- R10: `upd_done` is high for exactly one cycle, the cycle right after the edge that applies the update, that is UIP_LEAD + 1 clock edges after the edge that accepted the tick.
- R11: Writes to time bytes are accepted while counting runs and the next update starts from the written values; a write that lands on the same edge as the update wins for that byte while the other bytes advance.
- R12: The flags byte reads 0 and the status byte reads 0x80 (contents valid), whatever is written to them; a tick that arrives while an update window is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle request to run an update |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write enable for the addressed register |
| rdata | output | 8 | Registered read data for the address of the previous cycle |
| upd_done | output | 1 | One-cycle pulse after each applied update |

## Verification
Two activities can meet on the same edge: the update applying its carries and a software write, either to a time byte or to the freeze bit. The bench lands a minute write exactly on the update edge and expects the written minute while the seconds still advance, and it sets the freeze bit inside an open window and expects the seconds untouched and no `upd_done`. A second tick inside the window is also sent, and exactly one pulse and one added second are expected.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned NUM_TIME = 10;

  localparam logic [3:0] AD_SEC   = 4'd0;
  localparam logic [3:0] AD_MIN   = 4'd2;
  localparam logic [3:0] AD_HOUR  = 4'd4;
  localparam logic [3:0] AD_WDAY  = 4'd6;
  localparam logic [3:0] AD_DAY   = 4'd7;
  localparam logic [3:0] AD_MON   = 4'd8;
  localparam logic [3:0] AD_YEAR  = 4'd9;
  localparam logic [3:0] AD_CTLA  = 4'd10;
  localparam logic [3:0] AD_CTLB  = 4'd11;
  localparam logic [3:0] AD_FLAGS = 4'd12;
  localparam logic [3:0] AD_STAT  = 4'd13;

  localparam int BIT_FREEZE = 7;
  localparam int BIT_BINARY = 2;
  localparam int BIT_H24    = 1;

  localparam logic [6:0] CTLA_RST = 7'h26;
  localparam logic [7:0] CTLB_RST = 8'h02;
  localparam logic [7:0] STAT_VAL = 8'h80;

  // stored byte to plain count
  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin_mode);
    if (bin_mode) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // plain count to stored byte
  function automatic logic [7:0] from_bin(input logic [6:0] b, input logic bin_mode);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b - tens * 7'd10;
    if (bin_mode) return {1'b0, b};
    return {4'(tens), 4'(ones)};
  endfunction
endpackage

// File: rtl/cal_field_step.sv
module cal_field_step
  import cal_pkg::*;
(
  input  logic [7:0] cur,
  input  logic [6:0] lo,
  input  logic [6:0] hi,
  input  logic       bin_mode,
  output logic [7:0] nxt,
  output logic       wrap
);
  logic [6:0] v;

  always_comb begin
    v    = to_bin(cur, bin_mode);
    wrap = (v >= hi);
    nxt  = from_bin(wrap ? lo : v + 7'd1, bin_mode);
  end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  logic [7:0] cur,
  input  logic       h24,
  input  logic       bin_mode,
  output logic [7:0] nxt,
  output logic       wrap
);
  logic [6:0] v;
  logic [6:0] nb;
  logic       npm;
  logic [7:0] enc;

  always_comb begin
    v    = to_bin({1'b0, cur[6:0]}, bin_mode);
    wrap = 1'b0;
    npm  = cur[7];
    nb   = v + 7'd1;
    if (h24) begin
      npm  = 1'b0;
      wrap = (v >= 7'd23);
      if (wrap) nb = 7'd0;
    end else if (v == 7'd11) begin
      nb   = 7'd12;
      npm  = ~cur[7];
      wrap = cur[7];
    end else if (v >= 7'd12) begin
      nb = 7'd1;
    end
    enc = from_bin(nb, bin_mode);
    nxt = {npm, enc[6:0]};
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [7:0] month,
  input  logic [7:0] year,
  input  logic       bin_mode,
  output logic [6:0] last_day
);
  logic [6:0] m;
  logic [6:0] y;
  logic       leap;

  always_comb begin
    m    = to_bin(month, bin_mode);
    y    = to_bin(year, bin_mode);
    leap = ((y % 7'd4) == 7'd0);
    case (m)
      7'd2:                      last_day = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   last_day = 7'd30;
      default:                   last_day = 7'd31;
    endcase
  end
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned UIP_LEAD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  output logic [7:0]        rdata,
  output logic              upd_done
);
  localparam int unsigned CNT_W = (UIP_LEAD > 1) ? $clog2(UIP_LEAD) : 1;
  localparam int unsigned IDX_W = $clog2(NUM_TIME);

  logic [7:0]       tm_q   [NUM_TIME];
  logic [7:0]       tm_nxt [NUM_TIME];
  logic [6:0]       ctla_q;
  logic [7:0]       ctlb_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  logic freeze, bin_mode, h24;
  logic apply, cancel, accept;

  assign freeze   = ctlb_q[BIT_FREEZE];
  assign bin_mode = ctlb_q[BIT_BINARY];
  assign h24      = ctlb_q[BIT_H24];
  assign cancel   = wr_en && (addr == ADDR_W'(AD_CTLB)) && wdata[BIT_FREEZE];
  assign apply    = busy_q && (cnt_q == '0) && !cancel;
  assign accept   = tick && !busy_q && !freeze && !cancel;

  // carry chain
  logic [7:0] sec_n, min_n, hour_n, wday_n, day_n, mon_n, year_n;
  logic       c_sec, c_min, c_hour, c_day, c_mon, c_wday, c_year;
  logic [6:0] last_day;

  cal_field_step u_sec (.cur(tm_q[AD_SEC]), .lo(7'd0), .hi(7'd59), .bin_mode(bin_mode),
                        .nxt(sec_n), .wrap(c_sec));
  cal_field_step u_min (.cur(tm_q[AD_MIN]), .lo(7'd0), .hi(7'd59), .bin_mode(bin_mode),
                        .nxt(min_n), .wrap(c_min));
  cal_hour_step  u_hour (.cur(tm_q[AD_HOUR]), .h24(h24), .bin_mode(bin_mode),
                         .nxt(hour_n), .wrap(c_hour));
  cal_field_step u_wday (.cur(tm_q[AD_WDAY]), .lo(7'd1), .hi(7'd7), .bin_mode(bin_mode),
                         .nxt(wday_n), .wrap(c_wday));
  cal_month_len  u_mlen (.month(tm_q[AD_MON]), .year(tm_q[AD_YEAR]), .bin_mode(bin_mode),
                         .last_day(last_day));
  cal_field_step u_day (.cur(tm_q[AD_DAY]), .lo(7'd1), .hi(last_day), .bin_mode(bin_mode),
                        .nxt(day_n), .wrap(c_day));
  cal_field_step u_mon (.cur(tm_q[AD_MON]), .lo(7'd1), .hi(7'd12), .bin_mode(bin_mode),
                        .nxt(mon_n), .wrap(c_mon));
  cal_field_step u_year (.cur(tm_q[AD_YEAR]), .lo(7'd0), .hi(7'd99), .bin_mode(bin_mode),
                         .nxt(year_n), .wrap(c_year));

  logic go_min, go_hour, go_day, go_mon, go_year;
  assign go_min  = c_sec;
  assign go_hour = go_min && c_min;
  assign go_day  = go_hour && c_hour;
  assign go_mon  = go_day && c_day;
  assign go_year = go_mon && c_mon;

  always_comb begin
    for (int k = 0; k < NUM_TIME; k++) tm_nxt[k] = tm_q[k];
    tm_nxt[AD_SEC]  = sec_n;
    if (go_min)  tm_nxt[AD_MIN]  = min_n;
    if (go_hour) tm_nxt[AD_HOUR] = hour_n;
    if (go_day)  tm_nxt[AD_WDAY] = wday_n;
    if (go_day)  tm_nxt[AD_DAY]  = day_n;
    if (go_mon)  tm_nxt[AD_MON]  = mon_n;
    if (go_year) tm_nxt[AD_YEAR] = year_n;
  end

  // time and alarm bytes: a bus write outranks the update
  for (genvar i = 0; i < NUM_TIME; i++) begin : g_tm
    localparam logic [7:0] RV = (i == 6 || i == 7 || i == 8) ? 8'd1 : 8'd0;
    always_ff @(posedge clk) begin
      if (rst)                                   tm_q[i] <= RV;
      else if (wr_en && addr == ADDR_W'(i))      tm_q[i] <= wdata;
      else if (apply)                            tm_q[i] <= tm_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_q <= CTLA_RST;
      ctlb_q <= CTLB_RST;
    end else if (wr_en) begin
      if (addr == ADDR_W'(AD_CTLA)) ctla_q <= wdata[6:0];
      if (addr == ADDR_W'(AD_CTLB)) ctlb_q <= wdata;
    end
  end

  // update window sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= apply;
      if (cancel || apply) begin
        busy_q <= 1'b0;
      end else if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(UIP_LEAD - 1);
      end else if (busy_q) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign upd_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (addr < ADDR_W'(NUM_TIME)) begin
      rdata <= tm_q[IDX_W'(addr)];
    end else if (addr == ADDR_W'(AD_CTLA)) begin
      rdata <= {busy_q, ctla_q};
    end else if (addr == ADDR_W'(AD_CTLB)) begin
      rdata <= ctlb_q;
    end else if (addr == ADDR_W'(AD_STAT)) begin
      rdata <= STAT_VAL;
    end else begin
      rdata <= '0;
    end
  end

  // R8: frozen clock keeps its seconds unless software writes
  a_r8_frozen_seconds: assert property (@(posedge clk) disable iff (rst)
    (freeze && !wr_en) |=> $stable(tm_q[AD_SEC]));

  // R10: pulse is one cycle wide
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

  // R10: pulse follows the end of an open window
  a_r10_after_window: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_done) |-> ($past(busy_q) && !busy_q));

  // R9: an accepted tick opens the window
  a_r9_window_opens: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy_q && !freeze && !wr_en) |=> busy_q);

  // R8: a freeze write during a window ends it without a pulse
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_en && addr == ADDR_W'(AD_CTLB) && wdata[BIT_FREEZE]) |=> (!busy_q && !upd_done));
endmodule

// File: tb/cal_clock_core_test.sv
module cal_clock_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rdata;
  logic       upd_done;

  cal_clock_core #(.ADDR_W(4), .UIP_LEAD(L)) uut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rdata(rdata), .upd_done(upd_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  int total = 0;
  int bad = 0;
  logic rd_req = 1'b0;
  logic rd_seen = 1'b0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the queue
  always @(posedge clk) rd_seen <= rd_req;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        chk(0, "scoreboard underflow", 0, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(rdata === it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // R10: pulse lands L+1 negedges after the tick was driven
  task automatic tick_wait(input string tag);
    int k;
    tick_pulse();
    k = 1;
    while (!upd_done && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(k == L + 1, {tag, " R10 pulse timing"}, k, L + 1);
    @(negedge clk);
    chk(!upd_done, {tag, " R10 pulse width"}, upd_done, 0);
  endtask

  task automatic tick_nodone(input string tag);
    int seen;
    tick_pulse();
    seen = 0;
    for (int k = 0; k < L + 3; k++) begin
      if (upd_done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic load_hms(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state and map
    rd(4'd0,  8'h00, "R1 seconds reset");
    rd(4'd1,  8'h00, "R1 alarm reset");
    rd(4'd4,  8'h00, "R1 hour reset");
    rd(4'd6,  8'h01, "R1 weekday reset");
    rd(4'd7,  8'h01, "R1 day reset");
    rd(4'd8,  8'h01, "R1 month reset");
    rd(4'd9,  8'h00, "R1 year reset");
    rd(4'd10, 8'h26, "R1 ctl A reset");
    rd(4'd11, 8'h02, "R1 ctl B reset");
    rd(4'd12, 8'h00, "R12 flags reset");
    rd(4'd13, 8'h80, "R12 status reset");
    rd(4'd15, 8'h00, "R1 unmapped");
    wr(4'd3, 8'h42);
    rd(4'd3,  8'h42, "R1 alarm storage");

    // BCD 24h, end of century, Saturday
    wr(4'd11, 8'h82);
    load_hms(8'h58, 8'h59, 8'h23);
    wr(4'd6, 8'h07); wr(4'd7, 8'h31); wr(4'd8, 8'h12); wr(4'd9, 8'h99);
    tick_nodone("R8 tick while frozen gives no pulse");
    rd(4'd0, 8'h58, "R8 frozen seconds");
    wr(4'd11, 8'h02);
    tick_wait("R2 step");
    rd(4'd0, 8'h59, "R2 R5 bcd second");
    rd(4'd2, 8'h59, "R2 minute held");
    tick_wait("R3 rollover");
    rd(4'd0, 8'h00, "R2 second wrap");
    rd(4'd2, 8'h00, "R2 minute wrap");
    rd(4'd4, 8'h00, "R3 hour wrap");
    rd(4'd6, 8'h01, "R7 weekday wrap");
    rd(4'd7, 8'h01, "R6 day wrap 31");
    rd(4'd8, 8'h01, "R6 month wrap");
    rd(4'd9, 8'h00, "R6 year wrap");

    // binary, leap February
    wr(4'd11, 8'h86);
    load_hms(8'h3B, 8'h3B, 8'h17);
    wr(4'd6, 8'h03); wr(4'd7, 8'h1C); wr(4'd8, 8'h02); wr(4'd9, 8'h18);
    wr(4'd11, 8'h06);
    tick_wait("R5 binary");
    rd(4'd7, 8'h1D, "R6 R5 leap day 29");
    rd(4'd8, 8'h02, "R6 month kept");
    rd(4'd4, 8'h00, "R3 R5 binary hour wrap");
    rd(4'd6, 8'h04, "R7 weekday step");
    wr(4'd11, 8'h86);
    load_hms(8'h3B, 8'h3B, 8'h17);
    wr(4'd11, 8'h06);
    tick_wait("R6 leap end");
    rd(4'd7, 8'h01, "R6 leap wrap");
    rd(4'd8, 8'h03, "R6 month after leap");
    wr(4'd11, 8'h86);
    load_hms(8'h3B, 8'h3B, 8'h17);
    wr(4'd7, 8'h1E); wr(4'd8, 8'h04);
    wr(4'd11, 8'h06);
    tick_wait("R6 thirty");
    rd(4'd7, 8'h01, "R6 30-day month wrap");
    rd(4'd8, 8'h05, "R6 month 5 binary");

    // BCD non-leap February
    wr(4'd11, 8'h82);
    load_hms(8'h59, 8'h59, 8'h23);
    wr(4'd7, 8'h28); wr(4'd8, 8'h02); wr(4'd9, 8'h23);
    wr(4'd11, 8'h02);
    tick_wait("R6 common");
    rd(4'd7, 8'h01, "R6 common february wrap");
    rd(4'd8, 8'h03, "R6 march bcd");

    // 12-hour BCD
    wr(4'd11, 8'h80);
    load_hms(8'h59, 8'h59, 8'h11);
    wr(4'd7, 8'h05); wr(4'd8, 8'h01);
    wr(4'd11, 8'h00);
    tick_wait("R4 noon");
    rd(4'd4, 8'h92, "R4 11am to 12pm");
    rd(4'd7, 8'h05, "R4 no day carry at noon");
    wr(4'd11, 8'h80);
    wr(4'd0, 8'h59); wr(4'd2, 8'h59);
    wr(4'd11, 8'h00);
    tick_wait("R4 one");
    rd(4'd4, 8'h81, "R4 12pm to 1pm");
    wr(4'd11, 8'h80);
    load_hms(8'h59, 8'h59, 8'h91);
    wr(4'd11, 8'h00);
    tick_wait("R4 midnight");
    rd(4'd4, 8'h12, "R4 11pm to 12am");
    rd(4'd7, 8'h06, "R4 day carry at midnight");
    wr(4'd11, 8'h80);
    wr(4'd0, 8'h59); wr(4'd2, 8'h59);
    wr(4'd11, 8'h00);
    tick_wait("R4 am one");
    rd(4'd4, 8'h01, "R4 12am to 1am");

    // freeze inside an open window cancels it
    wr(4'd11, 8'h82);
    load_hms(8'h10, 8'h20, 8'h05);
    wr(4'd11, 8'h02);
    tick_pulse();
    wr(4'd11, 8'h82);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < L + 3; k++) begin
        if (upd_done) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R8 cancel gives no pulse", seen, 0);
    end
    rd(4'd10, 8'h26, "R9 flag low after cancel");
    rd(4'd0, 8'h10, "R8 cancelled update");

    // write landing on the update edge
    wr(4'd11, 8'h02);
    tick_pulse();
    repeat (L - 1) @(negedge clk);
    wr(4'd2, 8'h45);
    chk(upd_done === 1'b1, "R11 pulse with same-edge write", upd_done, 1);
    rd(4'd0, 8'h11, "R11 seconds still advance");
    rd(4'd2, 8'h45, "R11 same-edge write wins");

    // write while running
    wr(4'd0, 8'h30);
    tick_wait("R11 idle write");
    rd(4'd0, 8'h31, "R11 update from written value");

    // read-only and ignored bytes
    wr(4'd10, 8'hFF);
    rd(4'd10, 8'h7F, "R9 flag not writable");
    wr(4'd12, 8'hFF);
    rd(4'd12, 8'h00, "R12 flags ignore write");
    wr(4'd13, 8'h00);
    rd(4'd13, 8'h80, "R12 status ignores write");

    // flag during window, extra tick ignored
    tick_pulse();
    rd(4'd10, 8'hFF, "R9 flag high in window");
    tick_pulse();
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 12; k++) begin
        if (upd_done) seen++;
        @(negedge clk);
      end
      chk(seen == 1, "R12 one pulse for two ticks", seen, 1);
    end
    rd(4'd0, 8'h32, "R12 one second for two ticks");
    rd(4'd10, 8'h7F, "R9 flag low when idle");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    summary();
  end
endmodule